// File: doc/BRIEF.md
# FDDI Receive Line State Tracker

This block sits behind symbol alignment in an FDDI receive path. Each cycle in which `sym_valid` is high it takes one aligned 5-bit code symbol. It sorts the symbol into one of two groups. A data symbol yields a hex nibble. A control symbol yields one of Idle, Halt, J, K, T, R, S, Quiet, or Violation for any unassigned code. The decoded nibble and a control flag come out one cycle later, together with a `out_valid` strobe.

Alongside the decode, the block keeps the receive line state. It tracks run lengths of repeated Idle, Halt and Quiet symbols and the context of frame delimiters. From these it reports one of nine line states. An Idle run that lasts long enough first gives Idle and then Super Idle. A one-cycle pulse marks every change of the reported state. Run thresholds are given in symbol pairs and can be set by parameter. The defaults are 2 pairs for Idle, 8 for Super Idle, and 2 each for Halt and Quiet.

The next state is chosen by rules in a fixed order of precedence. The first rule that matches is used:

1. A J-K pair.
2. The run thresholds: Super Idle, Idle, Halt, Quiet.
3. Halt/Quiet alternation.
4. The Active hold and exit rules.
5. Violation.
6. The per-state hold rules.
7. Noise, when no other rule matches.

Two symbols count as consecutive if they are adjacent valid symbols. Cycles without a valid symbol do not break adjacency.

Top module: `rx_line_state`

## Requirements
- R1: Data codes decode to `out_nib` with `out_ctrl`=0, as follows: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R2: Control codes give `out_ctrl`=1 and an `out_nib` tag, as follows: 11111 Idle→0, 00100 Halt→1, 11000 J→2, 10001 K→3, 01101 T→4, 00111 R→5, 11001 S→6, 00000 Quiet→7. Every other code is Violation→8.
- R3: `out_valid` is high in exactly the cycle after each accepted symbol. `out_nib` and `out_ctrl` keep their last value while no symbol arrives.
- R4: The `line_state` codes are: unknown 0, noise 1, active 2, idle 3, super idle 4, halt 5, quiet 6, master 7, violation 8. After reset the outputs read unknown, with `out_valid`=0 and `ls_change`=0.
- R5: A J followed directly by a K enters active (2) from any state.
- R6: In active, the state holds on these symbols: data, T, R, S, J, K, and Idle runs shorter than the idle threshold. A Violation, Halt or Quiet symbol moves the state to noise (1).
- R7: Four consecutive Idle symbols (2 pairs) enter idle (3).
- R8: Sixteen consecutive Idle symbols (8 pairs) enter super idle (4).
- R9: Four consecutive Halt symbols enter halt (5). Four consecutive Quiet symbols enter quiet (6).
- R10: A Halt followed directly by a Quiet, or a Quiet followed directly by a Halt, enters master (7). Master holds on Halt and Quiet.
- R11: Outside active, a Violation enters violation (8). These states hold only on the listed symbols:
  - idle and super idle: Idle and J;
  - halt: Halt;
  - quiet: Quiet.
  Any other symbol in those states moves to noise. Unknown, noise and violation hold on any symbol that no earlier rule matches.
- R12: A run count restarts on any symbol that differs from the one before it. The count saturates, so an Idle run of any length stays in super idle.
- R13: `ls_change` is high for exactly the one cycle in which `line_state` shows a new value, and never at any other time. `line_state` changes only in the cycle after an accepted symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sym_valid | input | 1 | Strobe marking an aligned symbol on `sym_code` |
| sym_code | input | 5 | Aligned 5-bit code symbol |
| out_valid | output | 1 | Decoded symbol present on `out_nib`/`out_ctrl` |
| out_nib | output | 4 | Data nibble, or control tag when `out_ctrl` is set |
| out_ctrl | output | 1 | High for a control symbol, low for data |
| line_state | output | 4 | Current receive line state code |
| ls_change | output | 1 | One-cycle pulse when `line_state` changes |

## Verification
The assertions work from two assumptions about the input. First, `sym_code` is meaningful only when `sym_valid` is high. Second, adjacency for the J-K check means symbols on back-to-back cycles, and their antecedent demands exactly that. The stimulus drives inputs only between clock edges and keeps `sym_valid` low through reset. It also holds the input low until the internal reset release has completed. Pairs that must be consecutive are always sent on adjacent cycles. Separate directed runs insert idle cycles to show that gaps neither break a run nor move the state.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  // Symbol class; the value doubles as the control tag on out_nib.
  typedef enum logic [3:0] {
    K_I    = 4'd0,
    K_H    = 4'd1,
    K_J    = 4'd2,
    K_K    = 4'd3,
    K_T    = 4'd4,
    K_R    = 4'd5,
    K_S    = 4'd6,
    K_Q    = 4'd7,
    K_V    = 4'd8,
    K_DATA = 4'd9
  } sym_kind_e;

  typedef enum logic [3:0] {
    LS_UNKNOWN = 4'd0,
    LS_NOISE   = 4'd1,
    LS_ACTIVE  = 4'd2,
    LS_IDLE    = 4'd3,
    LS_SUPER   = 4'd4,
    LS_HALT    = 4'd5,
    LS_QUIET   = 4'd6,
    LS_MASTER  = 4'd7,
    LS_VIOL    = 4'd8
  } line_state_e;

  typedef struct packed {
    sym_kind_e  kind;
    logic [3:0] nib;
  } sym_dec_t;

endpackage

// File: rtl/lsd_sym_decode.sv
module lsd_sym_decode
  import lsd_pkg::*;
(
  input  logic [4:0] code,
  output sym_dec_t   dec
);

  always_comb begin
    dec.kind = K_DATA;
    dec.nib  = 4'h0;
    case (code)
      5'b11110: dec.nib = 4'h0;
      5'b01001: dec.nib = 4'h1;
      5'b10100: dec.nib = 4'h2;
      5'b10101: dec.nib = 4'h3;
      5'b01010: dec.nib = 4'h4;
      5'b01011: dec.nib = 4'h5;
      5'b01110: dec.nib = 4'h6;
      5'b01111: dec.nib = 4'h7;
      5'b10010: dec.nib = 4'h8;
      5'b10011: dec.nib = 4'h9;
      5'b10110: dec.nib = 4'hA;
      5'b10111: dec.nib = 4'hB;
      5'b11010: dec.nib = 4'hC;
      5'b11011: dec.nib = 4'hD;
      5'b11100: dec.nib = 4'hE;
      5'b11101: dec.nib = 4'hF;
      5'b11111: dec.kind = K_I;
      5'b00100: dec.kind = K_H;
      5'b11000: dec.kind = K_J;
      5'b10001: dec.kind = K_K;
      5'b01101: dec.kind = K_T;
      5'b00111: dec.kind = K_R;
      5'b11001: dec.kind = K_S;
      5'b00000: dec.kind = K_Q;
      default:  dec.kind = K_V;
    endcase
    if (dec.kind != K_DATA) dec.nib = dec.kind;
  end

endmodule

// File: rtl/lsd_run_track.sv
module lsd_run_track
  import lsd_pkg::*;
#(
  parameter int RUN_MAX = 16,
  localparam int RW = $clog2(RUN_MAX + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  sym_kind_e     kind,
  output sym_kind_e     prev_kind,
  output logic [RW-1:0] run_next
);

  localparam logic [RW-1:0] RUN_SAT = RW'(RUN_MAX);

  sym_kind_e     prev_q;
  logic [RW-1:0] run_q;
  logic          repeatable;

  always_comb begin
    repeatable = (kind == K_I) || (kind == K_H) || (kind == K_Q);
    if (!repeatable)          run_next = '0;
    else if (kind != prev_q)  run_next = RW'(1);
    else if (run_q == RUN_SAT) run_next = RUN_SAT;
    else                      run_next = run_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= K_V;
      run_q  <= '0;
    end else if (en) begin
      prev_q <= kind;
      run_q  <= run_next;
    end
  end

  assign prev_kind = prev_q;

endmodule

// File: rtl/lsd_state_fsm.sv
module lsd_state_fsm
  import lsd_pkg::*;
#(
  parameter int IDLE_PAIRS  = 2,
  parameter int SUPER_PAIRS = 8,
  parameter int HALT_PAIRS  = 2,
  parameter int QUIET_PAIRS = 2,
  parameter int RW          = 5
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  sym_kind_e     kind,
  input  sym_kind_e     prev_kind,
  input  logic [RW-1:0] run_next,
  output line_state_e   state,
  output logic          change
);

  localparam logic [RW-1:0] IDLE_RUN  = RW'(2 * IDLE_PAIRS);
  localparam logic [RW-1:0] SUPER_RUN = RW'(2 * SUPER_PAIRS);
  localparam logic [RW-1:0] HALT_RUN  = RW'(2 * HALT_PAIRS);
  localparam logic [RW-1:0] QUIET_RUN = RW'(2 * QUIET_PAIRS);

  line_state_e state_q, state_d;
  logic        change_q;
  logic        hold_ok;

  always_comb begin
    case (state_q)
      LS_IDLE, LS_SUPER: hold_ok = (kind == K_I) || (kind == K_J);
      LS_HALT:           hold_ok = (kind == K_H);
      LS_QUIET:          hold_ok = (kind == K_Q);
      LS_MASTER:         hold_ok = (kind == K_H) || (kind == K_Q);
      default:           hold_ok = 1'b1;
    endcase

    if (prev_kind == K_J && kind == K_K)
      state_d = LS_ACTIVE;
    else if (kind == K_I && run_next >= SUPER_RUN)
      state_d = LS_SUPER;
    else if (kind == K_I && run_next >= IDLE_RUN)
      state_d = LS_IDLE;
    else if (kind == K_H && run_next >= HALT_RUN)
      state_d = LS_HALT;
    else if (kind == K_Q && run_next >= QUIET_RUN)
      state_d = LS_QUIET;
    else if ((prev_kind == K_H && kind == K_Q) || (prev_kind == K_Q && kind == K_H))
      state_d = LS_MASTER;
    else if (state_q == LS_ACTIVE)
      state_d = (kind == K_V || kind == K_H || kind == K_Q) ? LS_NOISE : LS_ACTIVE;
    else if (kind == K_V)
      state_d = LS_VIOL;
    else if (hold_ok)
      state_d = state_q;
    else
      state_d = LS_NOISE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LS_UNKNOWN;
      change_q <= 1'b0;
    end else begin
      change_q <= en && (state_d != state_q);
      if (en) state_q <= state_d;
    end
  end

  assign state  = state_q;
  assign change = change_q;

endmodule

// File: rtl/rx_line_state.sv
module rx_line_state
  import lsd_pkg::*;
#(
  parameter int IDLE_PAIRS  = 2,
  parameter int SUPER_PAIRS = 8,
  parameter int HALT_PAIRS  = 2,
  parameter int QUIET_PAIRS = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [4:0] sym_code,
  output logic       out_valid,
  output logic [3:0] out_nib,
  output logic       out_ctrl,
  output logic [3:0] line_state,
  output logic       ls_change
);

  localparam int MAX_A   = (IDLE_PAIRS > SUPER_PAIRS) ? IDLE_PAIRS : SUPER_PAIRS;
  localparam int MAX_B   = (HALT_PAIRS > QUIET_PAIRS) ? HALT_PAIRS : QUIET_PAIRS;
  localparam int RUN_MAX = 2 * ((MAX_A > MAX_B) ? MAX_A : MAX_B);
  localparam int RW      = $clog2(RUN_MAX + 1);

  logic [1:0]    rst_sync;
  logic          rst_core_n;
  sym_dec_t      dec;
  sym_kind_e     prev_kind;
  logic [RW-1:0] run_next;
  line_state_e   state;
  logic          out_valid_q;
  logic [3:0]    out_nib_q;
  logic          out_ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  lsd_sym_decode u_dec (
    .code (sym_code),
    .dec  (dec)
  );

  lsd_run_track #(.RUN_MAX(RUN_MAX)) u_run (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .en        (sym_valid),
    .kind      (dec.kind),
    .prev_kind (prev_kind),
    .run_next  (run_next)
  );

  lsd_state_fsm #(
    .IDLE_PAIRS  (IDLE_PAIRS),
    .SUPER_PAIRS (SUPER_PAIRS),
    .HALT_PAIRS  (HALT_PAIRS),
    .QUIET_PAIRS (QUIET_PAIRS),
    .RW          (RW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .en        (sym_valid),
    .kind      (dec.kind),
    .prev_kind (prev_kind),
    .run_next  (run_next),
    .state     (state),
    .change    (ls_change)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid_q <= 1'b0;
      out_nib_q   <= 4'h0;
      out_ctrl_q  <= 1'b0;
    end else begin
      out_valid_q <= sym_valid;
      if (sym_valid) begin
        out_nib_q  <= dec.nib;
        out_ctrl_q <= (dec.kind != K_DATA);
      end
    end
  end

  assign out_valid  = out_valid_q;
  assign out_nib    = out_nib_q;
  assign out_ctrl   = out_ctrl_q;
  assign line_state = state;

endmodule

// File: rtl/lsd_checker.sv
module lsd_checker
  import lsd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sym_valid,
  input logic [4:0] sym_code,
  input logic       out_valid,
  input logic [3:0] out_nib,
  input logic       out_ctrl,
  input logic [3:0] line_state,
  input logic       ls_change
);

  a_r3_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> out_valid);

  a_r3_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> !out_valid);

  a_r2_idle_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code == 5'b11111) |=> (out_ctrl && out_nib == 4'h0));

  a_r5_jk_active: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sym_valid) && $past(sym_code) == 5'b11000 &&
     sym_valid && sym_code == 5'b10001) |=> (line_state == LS_ACTIVE));

  a_r6_active_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_ACTIVE && sym_valid && sym_code == 5'b00001) |=>
      (line_state == LS_NOISE));

  a_r13_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    ls_change |-> (line_state != $past(line_state)));

  a_r13_change_means_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state != $past(line_state)) |-> ls_change);

  a_r13_quiet_input: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> ($stable(line_state) && !ls_change));

  a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    line_state <= 4'd8);

endmodule

bind rx_line_state lsd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .sym_valid  (sym_valid),
  .sym_code   (sym_code),
  .out_valid  (out_valid),
  .out_nib    (out_nib),
  .out_ctrl   (out_ctrl),
  .line_state (line_state),
  .ls_change  (ls_change)
);

// File: tb/rx_line_state_tb.sv
module rx_line_state_tb;

  logic       clk;
  logic       rst_n;
  logic       sym_valid;
  logic [4:0] sym_code;
  logic       out_valid;
  logic [3:0] out_nib;
  logic       out_ctrl;
  logic [3:0] line_state;
  logic       ls_change;

  int checks;
  int failures;

  rx_line_state u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_valid  (sym_valid),
    .sym_code   (sym_code),
    .out_valid  (out_valid),
    .out_nib    (out_nib),
    .out_ctrl   (out_ctrl),
    .line_state (line_state),
    .ls_change  (ls_change)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Symbol codes used in directed runs.
  localparam logic [4:0] C_I = 5'b11111, C_H = 5'b00100, C_J = 5'b11000,
                         C_K = 5'b10001, C_T = 5'b01101, C_R = 5'b00111,
                         C_S = 5'b11001, C_Q = 5'b00000, C_V = 5'b00001,
                         C_D5 = 5'b01011;

  // Reference model state.
  int m_state, m_prev, m_run;
  int exp_valid, exp_nib, exp_ctrl, exp_chg;
  bit pending;
  string pend_tag;

  task automatic check(input string tag, input bit ok, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [4:0] c, output int nib);
    int k;
    k = 9;
    nib = 0;
    case (c)
      5'b11110: nib = 0;  5'b01001: nib = 1;  5'b10100: nib = 2;  5'b10101: nib = 3;
      5'b01010: nib = 4;  5'b01011: nib = 5;  5'b01110: nib = 6;  5'b01111: nib = 7;
      5'b10010: nib = 8;  5'b10011: nib = 9;  5'b10110: nib = 10; 5'b10111: nib = 11;
      5'b11010: nib = 12; 5'b11011: nib = 13; 5'b11100: nib = 14; 5'b11101: nib = 15;
      5'b11111: k = 0; 5'b00100: k = 1; 5'b11000: k = 2; 5'b10001: k = 3;
      5'b01101: k = 4; 5'b00111: k = 5; 5'b11001: k = 6; 5'b00000: k = 7;
      default:  k = 8;
    endcase
    if (k != 9) nib = k;
    return k;
  endfunction

  function automatic void model_step(input logic [4:0] c);
    int k, nib, n, ns;
    bit ok;
    k = kind_of(c, nib);
    if (!(k == 0 || k == 1 || k == 7)) n = 0;
    else if (k != m_prev) n = 1;
    else n = (m_run >= 16) ? 16 : m_run + 1;
    if (m_prev == 2 && k == 3) ns = 2;
    else if (k == 0 && n >= 16) ns = 4;
    else if (k == 0 && n >= 4) ns = 3;
    else if (k == 1 && n >= 4) ns = 5;
    else if (k == 7 && n >= 4) ns = 6;
    else if ((m_prev == 1 && k == 7) || (m_prev == 7 && k == 1)) ns = 7;
    else if (m_state == 2) ns = (k == 8 || k == 1 || k == 7) ? 1 : 2;
    else if (k == 8) ns = 8;
    else begin
      case (m_state)
        3, 4:    ok = (k == 0 || k == 2);
        5:       ok = (k == 1);
        6:       ok = (k == 7);
        7:       ok = (k == 1 || k == 7);
        default: ok = 1'b1;
      endcase
      ns = ok ? m_state : 1;
    end
    exp_chg  = (ns != m_state) ? 1 : 0;
    exp_valid = 1;
    exp_nib  = nib;
    exp_ctrl = (k != 9) ? 1 : 0;
    m_run = n;
    m_prev = k;
    m_state = ns;
  endfunction

  task automatic verify_pending();
    if (pending) begin
      check("R3", out_valid == exp_valid[0], out_valid, exp_valid, "out_valid");
      if (exp_ctrl == 1)
        check("R2", out_nib == exp_nib[3:0] && out_ctrl, {out_ctrl, out_nib}, 16 + exp_nib, "ctrl tag");
      else
        check("R1", out_nib == exp_nib[3:0] && !out_ctrl, {out_ctrl, out_nib}, exp_nib, "data nibble");
      check(pend_tag, line_state == m_state[3:0], line_state, m_state, "line_state");
      check("R13", ls_change == exp_chg[0], ls_change, exp_chg, "ls_change");
    end
  endtask

  task automatic send(input logic [4:0] c, input string tag);
    @(negedge clk);
    verify_pending();
    sym_valid = 1'b1;
    sym_code  = c;
    model_step(c);
    pend_tag = tag;
    pending = 1'b1;
  endtask

  task automatic gap(input string tag);
    @(negedge clk);
    verify_pending();
    sym_valid = 1'b0;
    sym_code  = 5'b10101;
    exp_valid = 0;
    exp_chg   = 0;
    pend_tag  = tag;
    pending   = 1'b1;
  endtask

  task automatic send_n(input logic [4:0] c, input int n, input string tag);
    for (int i = 0; i < n; i++) send(c, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    checks = 0; failures = 0;
    m_state = 0; m_prev = 8; m_run = 0;
    exp_valid = 0; exp_nib = 0; exp_ctrl = 0; exp_chg = 0;
    pending = 1'b0; pend_tag = "R4";
    rst_n = 1'b0; sym_valid = 1'b0; sym_code = 5'b0;
    repeat (3) begin
      @(negedge clk);
      check("R4", line_state == 4'd0 && !out_valid && !ls_change,
            {out_valid, ls_change, line_state}, 0, "reset outputs");
    end
    rst_n = 1'b1;
    pending = 1'b1;
    repeat (4) gap("R4");

    // R1 R2: sweep of every code; state follows the model (R11).
    for (int c = 0; c < 32; c++) send(5'(c), "R11");
    gap("R3");
    gap("R13");

    // R7 then R8 with a gap inside the run, then R12 saturation.
    send_n(C_I, 4, "R7");
    gap("R13");
    send_n(C_I, 12, "R8");
    send_n(C_I, 30, "R12");
    // R5 from super idle, R6 active holds.
    send(C_J, "R11");
    send(C_K, "R5");
    send_n(C_D5, 5, "R6");
    send(C_T, "R6"); send(C_R, "R6"); send(C_S, "R6");
    send(C_J, "R6"); send(C_K, "R6");
    send_n(C_I, 3, "R6");
    send(C_I, "R7");
    send(C_J, "R11"); send(C_K, "R5");
    send(C_V, "R6");
    send(C_J, "R5"); send(C_K, "R5");
    send(C_H, "R6");
    send(C_J, "R5"); send(C_K, "R5");
    send(C_Q, "R6");
    // R9 halt and quiet.
    send_n(C_H, 4, "R9");
    send(C_H, "R9");
    send_n(C_Q, 4, "R9");
    // R10 master.
    send(C_H, "R10"); send(C_Q, "R10"); send(C_H, "R10");
    send(C_D5, "R11");
    // R11 violation and noise.
    send(C_V, "R11");
    send(C_D5, "R11");
    send_n(C_I, 4, "R7");
    send(C_D5, "R11");
    // R12 restart of a run.
    send_n(C_I, 15, "R12");
    send(C_H, "R12");
    send_n(C_I, 3, "R12");
    send(C_I, "R7");
    gap("R13");

    // Pseudo-random mix biased to repeated symbols.
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15] && lfsr[14]) gap("R13");
      else if (lfsr[3:0] < 4'd6) send(C_I, "R8");
      else if (lfsr[3:0] < 4'd8) send(C_H, "R9");
      else if (lfsr[3:0] < 4'd10) send(C_Q, "R10");
      else if (lfsr[3:0] < 4'd11) send(C_J, "R5");
      else if (lfsr[3:0] < 4'd12) send(C_K, "R5");
      else send(lfsr[8:4], "R11");
    end
    gap("R3");
    gap("R13");
    @(negedge clk);
    verify_pending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule